// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Logic

This block is the interrupt section of a 16550-style UART register file. It holds the interrupt enable register, ranks the status conditions that the rest of the UART reports (line error, received data, receive timeout, transmitter holding register empty, modem change), and presents the highest-ranked enabled condition as an identification code. It also drives a level interrupt line that is active whenever any enabled condition is pending.

The block sits on the UART's byte-wide register bus. Each register access that acknowledges a source produces a one-cycle clear pulse, and the owning logic uses that pulse to drop its status. The transmitter-empty condition is the exception: it is tracked by a pending flag inside this block. Reading the identification register while it reports transmitter-empty clears that flag. A new empty event re-arms it. Enabling the source while the holding register is already empty also re-arms it.

The bus map uses these offsets: 0 for receive buffer reads and holding register writes, 1 for the enable register, 2 for the identification register (read only), 5 for line status and 6 for modem status.

Top module: `uart_irq_ident`

## Requirements
- R1: Sources are ranked, from highest to lowest: line error, then receive data (including timeout), then transmitter-empty, then modem change. The identification register shows only the highest-ranked enabled active source.
- R2: A source is reported only when its enable bit is 1 and its condition is active. The enable bits are: bit0 receive data, bit1 transmitter-empty, bit2 line error, bit3 modem change. The codes are: line 0x06, receive 0x04, transmitter-empty 0x02, modem 0x00.
- R3: With no enabled source active, bit0 of the identification value is 1 and `irq` is low. Otherwise bit0 is 0 and `irq` is high.
- R4: When `fifo_en` is 1, bits 7:6 of the identification value read 11. When it is 0, they read 00.
- R5: The transmitter-empty pending flag is set on a rising edge of `st_thr_empty`. It is also set when an enable write changes bit1 from 0 to 1 while `st_thr_empty` is 1.
- R6: A read of offset 2 that reports transmitter-empty clears that flag from the next cycle on. So do a write to offset 0 and any other enable write.
- R7: A read of offset 0 pulses `clr_rx` and a read of offset 5 pulses `clr_line`. A read of offset 6 pulses `clr_modem`. A write to offset 0, or a read of offset 2 while it reports transmitter-empty, pulses `clr_thre`. Each pulse lasts for the cycle of the access.
- R8: When `fifo_en` is 1, an enabled receive timeout reports 0x0C, which takes precedence over 0x04. When `fifo_en` is 0, bit3 reads 0 and the timeout input is ignored.
- R9: Enable writes keep bits 3:0 only, and bits 7:4 read back as 0. Writes to offset 2 change neither register. While `rd_en` is low, and for unmapped offsets, `rd_data` is 0.
- R10: After reset the enable register is 0, the identification value reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational during `rd_en` |
| st_line_err | input | 1 | Line error condition |
| st_rx_avail | input | 1 | Receive data available |
| st_rx_timeout | input | 1 | Receive timeout |
| st_thr_empty | input | 1 | Holding register empty |
| st_modem_chg | input | 1 | Modem status change |
| fifo_en | input | 1 | FIFO-enable bit of the FIFO control register |
| irq | output | 1 | Level interrupt request |
| clr_rx | output | 1 | Receive data acknowledge pulse |
| clr_line | output | 1 | Line status acknowledge pulse |
| clr_modem | output | 1 | Modem status acknowledge pulse |
| clr_thre | output | 1 | Transmitter-empty acknowledge pulse |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that `st_thr_empty` never rises in the same cycle as an enable write, because otherwise the flag update would depend on two events at once. The stimulus performs one access at a time, with idle cycles between accesses. It changes the status inputs only on idle cycles, a clock after the edge, so each identification value is read back after the pending flag has settled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int unsigned IEN_W = 4;
   localparam int unsigned IEN_RX    = 0;
   localparam int unsigned IEN_THRE  = 1;
   localparam int unsigned IEN_LINE  = 2;
   localparam int unsigned IEN_MODEM = 3;

   typedef enum logic [3:0] {
      ID_NONE  = 4'h1,
      ID_LINE  = 4'h6,
      ID_RX    = 4'h4,
      ID_TMO   = 4'hC,
      ID_THRE  = 4'h2,
      ID_MODEM = 4'h0
   } id_code_e;

   localparam logic [1:0] ID_FIFO_BITS = 2'b11;
endpackage

// File: rtl/uart_irq_ier_reg.sv
module uart_irq_ier_reg
   import uart_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic [IEN_W-1:0]  ier_q
);
   if (DATA_W < IEN_W) begin : g_bad_width
      $error("uart_irq_ier_reg: DATA_W too small for enable bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ier_q <= '0;
      else if (wr_stb)
         ier_q <= wr_data[IEN_W-1:0];
   end

   AST_IER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (ier_q == $past(wr_data[IEN_W-1:0])))
      else $error("enable write not captured"); // R9
endmodule

// File: rtl/uart_irq_thre_track.sv
module uart_irq_thre_track (
   input  logic clk,
   input  logic rst_n,
   input  logic empty,
   input  logic ier_thre_old,
   input  logic ier_wr,
   input  logic ier_thre_new,
   input  logic thr_wr,
   input  logic iir_rd_thre,
   output logic pend
);
   logic empty_q;
   logic rise;
   logic arm;
   logic drop;

   assign rise = empty & ~empty_q;
   assign arm  = ier_wr & ier_thre_new & ~ier_thre_old & empty;
   assign drop = thr_wr | iir_rd_thre | ier_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         pend    <= 1'b0;
      end else begin
         empty_q <= empty;
         if (rise | arm)
            pend <= 1'b1;
         else if (drop)
            pend <= 1'b0;
      end
   end

   AST_THRE_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !empty_q) |=> pend)
      else $error("empty edge did not arm"); // R5

   AST_THRE_IIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd_thre && !rise && !arm) |=> !pend)
      else $error("reporting read did not clear"); // R6
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [IEN_W-1:0]  ier,
   input  logic              line_err,
   input  logic              rx_avail,
   input  logic              rx_tmo,
   input  logic              thre_pend,
   input  logic              modem_chg,
   input  logic              fifo_en,
   output logic [DATA_W-1:0] iir,
   output logic              thre_sel
);
   id_code_e code;
   logic     tmo_act;

   assign tmo_act = rx_tmo & fifo_en;

   always_comb begin
      code = ID_NONE;
      if (ier[IEN_LINE] && line_err)
         code = ID_LINE;
      else if (ier[IEN_RX] && tmo_act)
         code = ID_TMO;
      else if (ier[IEN_RX] && rx_avail)
         code = ID_RX;
      else if (ier[IEN_THRE] && thre_pend)
         code = ID_THRE;
      else if (ier[IEN_MODEM] && modem_chg)
         code = ID_MODEM;
   end

   always_comb begin
      iir = '0;
      iir[3:0] = code;
      iir[7:6] = fifo_en ? ID_FIFO_BITS : 2'b00;
   end

   assign thre_sel = (code == ID_THRE);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int unsigned ADDR_W         = 3,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned OFS_DATA       = 0,
   parameter int unsigned OFS_IER        = 1,
   parameter int unsigned OFS_IIR        = 2,
   parameter int unsigned OFS_LSR        = 5,
   parameter int unsigned OFS_MSR        = 6,
   parameter bit          IRQ_ACTIVE_LOW = 1'b0,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              st_line_err,
   input  logic              st_rx_avail,
   input  logic              st_rx_timeout,
   input  logic              st_thr_empty,
   input  logic              st_modem_chg,
   input  logic              fifo_en,
   output logic              irq,
   output logic              clr_rx,
   output logic              clr_line,
   output logic              clr_modem,
   output logic              clr_thre
);
   localparam int unsigned NUM_OFS = 1 << ADDR_W;

   if (DATA_W != 8) begin : g_bad_data
      $error("uart_irq_ident: DATA_W must be 8");
   end
   if (OFS_DATA >= NUM_OFS || OFS_IER >= NUM_OFS || OFS_IIR >= NUM_OFS ||
       OFS_LSR >= NUM_OFS || OFS_MSR >= NUM_OFS) begin : g_bad_ofs
      $error("uart_irq_ident: offset outside address range");
   end

   logic              hit_data, hit_ier, hit_iir, hit_lsr, hit_msr;
   logic              ier_wr, thr_wr, iir_rd;
   logic [IEN_W-1:0]  ier;
   logic              thre_pend;
   logic              thre_act;
   logic              thre_sel;
   logic [DATA_W-1:0] iir;
   logic              req;

   assign hit_data = (addr == ADDR_W'(OFS_DATA));
   assign hit_ier  = (addr == ADDR_W'(OFS_IER));
   assign hit_iir  = (addr == ADDR_W'(OFS_IIR));
   assign hit_lsr  = (addr == ADDR_W'(OFS_LSR));
   assign hit_msr  = (addr == ADDR_W'(OFS_MSR));

   assign ier_wr = wr_en & hit_ier;
   assign thr_wr = wr_en & hit_data;
   assign iir_rd = rd_en & hit_iir;

   uart_irq_ier_reg #(.DATA_W(DATA_W)) u_ier (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (ier_wr),
      .wr_data (wr_data),
      .ier_q   (ier)
   );

   uart_irq_thre_track u_thre (
      .clk          (clk),
      .rst_n        (rst_n),
      .empty        (st_thr_empty),
      .ier_thre_old (ier[IEN_THRE]),
      .ier_wr       (ier_wr),
      .ier_thre_new (wr_data[IEN_THRE]),
      .thr_wr       (thr_wr),
      .iir_rd_thre  (iir_rd & thre_sel),
      .pend         (thre_pend)
   );

   assign thre_act = thre_pend & st_thr_empty;

   uart_irq_prio #(.DATA_W(DATA_W)) u_prio (
      .ier       (ier),
      .line_err  (st_line_err),
      .rx_avail  (st_rx_avail),
      .rx_tmo    (st_rx_timeout),
      .thre_pend (thre_act),
      .modem_chg (st_modem_chg),
      .fifo_en   (fifo_en),
      .iir       (iir),
      .thre_sel  (thre_sel)
   );

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (hit_ier)
            rd_data[IEN_W-1:0] = ier;
         else if (hit_iir)
            rd_data = iir;
      end
   end

   assign clr_rx    = rd_en & hit_data;
   assign clr_line  = rd_en & hit_lsr;
   assign clr_modem = rd_en & hit_msr;
   assign clr_thre  = thr_wr | (iir_rd & thre_sel);

   assign req = ~iir[0];

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic req_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            req_q <= 1'b0;
         else
            req_q <= req;
      end
      assign irq = req_q ^ IRQ_ACTIVE_LOW;
   end else begin : g_irq_comb
      assign irq = req ^ IRQ_ACTIVE_LOW;

      AST_IRQ_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         (ier[IEN_LINE] && st_line_err) |-> (irq == !IRQ_ACTIVE_LOW))
         else $error("line error not raising irq"); // R3
   end

   AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ier[IEN_LINE] && st_line_err) |-> (iir[3:0] == ID_LINE))
      else $error("line error not top ranked"); // R1

   AST_IDLE_NOINT: assert property (@(posedge clk) disable iff (!rst_n)
      !((ier[IEN_LINE] && st_line_err) || (ier[IEN_RX] && st_rx_avail) ||
        (ier[IEN_RX] && st_rx_timeout && fifo_en) ||
        (ier[IEN_THRE] && thre_act) || (ier[IEN_MODEM] && st_modem_chg))
      |-> iir[0])
      else $error("interrupt reported with nothing enabled"); // R3

   AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && hit_iir |-> (rd_data[7:6] == {2{fifo_en}}))
      else $error("FIFO indication wrong"); // R4

   AST_NO_TMO_NONFIFO: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> !iir[3])
      else $error("timeout bit set outside FIFO mode"); // R8

   AST_IIR_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_iir) |=> $stable(ier))
      else $error("write to read-only offset changed enables"); // R9
endmodule

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb;
   typedef struct {
      logic [11:0] exp;
      string       tag;
   } sb_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       st_line_err = 0, st_rx_avail = 0, st_rx_timeout = 0;
   logic       st_thr_empty = 0, st_modem_chg = 0, fifo_en = 0;
   logic       irq, clr_rx, clr_line, clr_modem, clr_thre;

   int n_cmp = 0;
   int n_bad = 0;
   sb_item_t sb_q[$];

   always #2.5 clk = ~clk;

   uart_irq_ident u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .st_line_err(st_line_err),
      .st_rx_avail(st_rx_avail), .st_rx_timeout(st_rx_timeout),
      .st_thr_empty(st_thr_empty), .st_modem_chg(st_modem_chg),
      .fifo_en(fifo_en), .irq(irq), .clr_rx(clr_rx), .clr_line(clr_line),
      .clr_modem(clr_modem), .clr_thre(clr_thre)
   );

   // monitor: pops one expected item per access, observed at the falling edge
   always @(negedge clk) begin
      if (rd_en || wr_en) begin
         logic [11:0] got;
         sb_item_t    it;
         got = {clr_thre, clr_modem, clr_line, clr_rx, rd_data};
         n_cmp++;
         if (sb_q.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard empty: actual %03h expected none", got);
         end else begin
            it = sb_q.pop_front();
            if (got !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %03h expected %03h", it.tag, got, it.exp);
            end
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   // clr bits order: thre, modem, line, rx
   task automatic rd(input logic [2:0] a, input logic [7:0] d, input logic [3:0] c,
                     input string tag);
      sb_item_t it;
      it.exp = {c, d};
      it.tag = tag;
      sb_q.push_back(it);
      addr = a; rd_en = 1'b1;
      idle(1);
      rd_en = 1'b0;
      idle(1);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [3:0] c,
                     input string tag);
      sb_item_t it;
      it.exp = {c, 8'h00};
      it.tag = tag;
      sb_q.push_back(it);
      addr = a; wr_data = d; wr_en = 1'b1;
      idle(1);
      wr_en = 1'b0;
      idle(1);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      n_cmp++;
      if (irq !== e) begin
         n_bad++;
         $display("FAIL %s irq: actual %0b expected %0b", tag, irq, e);
      end
   endtask

   initial begin : watchdog
      #(5 * 20000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      idle(3);
      chk_irq(1'b0, "R10 during reset");
      rst_n = 1'b1;
      idle(2);
      rd(3'd2, 8'h01, 4'b0000, "R10 iir after reset");
      rd(3'd1, 8'h00, 4'b0000, "R10 ier after reset");
      chk_irq(1'b0, "R10");

      wr(3'd1, 8'hFF, 4'b0000, "R9 ier write");
      rd(3'd1, 8'h0F, 4'b0000, "R9 ier masked");
      rd(3'd2, 8'h01, 4'b0000, "R3 idle no int");
      chk_irq(1'b0, "R3 idle");

      st_modem_chg = 1; idle(1);
      rd(3'd2, 8'h00, 4'b0000, "R2 modem code");
      chk_irq(1'b1, "R3 modem");
      st_thr_empty = 1; idle(2);
      rd(3'd2, 8'h02, 4'b1000, "R1 thre over modem, R7 iir clr_thre");
      rd(3'd2, 8'h00, 4'b0000, "R6 thre cleared by iir read");

      st_thr_empty = 0; idle(1);
      st_thr_empty = 1; idle(2);
      st_rx_avail = 1; idle(1);
      rd(3'd2, 8'h04, 4'b0000, "R1 rx over thre");
      st_line_err = 1; idle(1);
      rd(3'd2, 8'h06, 4'b0000, "R1 line first");
      st_line_err = 0; st_rx_avail = 0; idle(1);
      wr(3'd0, 8'h55, 4'b1000, "R7 thr write clr_thre");
      rd(3'd2, 8'h00, 4'b0000, "R6 thre cleared by thr write");

      wr(3'd1, 8'h0D, 4'b0000, "R5 disable thre");
      rd(3'd2, 8'h00, 4'b0000, "R2 thre disabled");
      wr(3'd1, 8'h0F, 4'b0000, "R5 enable thre");
      rd(3'd2, 8'h02, 4'b1000, "R5 rearm on enable while empty");
      st_thr_empty = 0; idle(1);
      st_thr_empty = 1; idle(2);
      wr(3'd1, 8'h0F, 4'b0000, "R6 ier rewrite");
      rd(3'd2, 8'h00, 4'b0000, "R6 ier write clears thre");

      st_modem_chg = 0; idle(1);
      rd(3'd2, 8'h01, 4'b0000, "R3 all idle");
      chk_irq(1'b0, "R3 all idle");

      fifo_en = 1; idle(1);
      rd(3'd2, 8'hC1, 4'b0000, "R4 fifo bits");
      st_rx_avail = 1; st_rx_timeout = 1; idle(1);
      rd(3'd2, 8'hCC, 4'b0000, "R8 timeout in fifo mode");
      fifo_en = 0; idle(1);
      rd(3'd2, 8'h04, 4'b0000, "R8 non-fifo no bit3");
      st_rx_avail = 0; idle(1);
      rd(3'd2, 8'h01, 4'b0000, "R8 timeout ignored non-fifo");
      chk_irq(1'b0, "R8 timeout ignored");
      st_rx_timeout = 0;

      wr(3'd1, 8'h00, 4'b0000, "R2 all disabled");
      st_line_err = 1; idle(1);
      rd(3'd2, 8'h01, 4'b0000, "R2 disabled line not reported");
      chk_irq(1'b0, "R2 disabled");
      wr(3'd1, 8'h04, 4'b0000, "R2 enable line");
      rd(3'd2, 8'h06, 4'b0000, "R2 line reported");
      wr(3'd2, 8'hFF, 4'b0000, "R9 write to iir offset");
      rd(3'd1, 8'h04, 4'b0000, "R9 ier unchanged");
      rd(3'd2, 8'h06, 4'b0000, "R9 iir unchanged");

      rd(3'd0, 8'h00, 4'b0001, "R7 rbr read clr_rx");
      rd(3'd5, 8'h00, 4'b0010, "R7 lsr read clr_line");
      rd(3'd6, 8'h00, 4'b0100, "R7 msr read clr_modem");
      st_line_err = 0; idle(2);

      n_cmp++;
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard leftover: actual %0d expected 0", sb_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule